// File: doc/BRIEF.md
# DSP Circular and Bit-Reverse Address Generator

This unit generates data-memory addresses for a DSP data path. It holds one pointer together with a lower and an upper buffer bound, a signed stride and an FFT size. Each cycle, `addr_o` shows the address for the current access. On a clock edge where `step_i` is high, the pointer moves according to the selected mode. Linear mode moves the pointer by the stride. Circular mode does the same, but wraps between the two bounds, so an endless sample stream can sit in a finite buffer.

Bit-reverse mode serves FFT reordering. An internal index counts up by one on each step. The address is the lower bound plus that index with its low N bits mirrored, where N is the log2 of the FFT point count.

Registers are written through a single load port. A selector on that port picks the target register.

Top module: `dsp_agu`

## Requirements
- R1: After reset, the pointer is 0x0000, the lower bound is 0x0000 and the upper bound is 0xFFFF. The stride is +1, the FFT size N is 2 and the bit-reverse index is 0.
- R2: When `ld_en_i` is high, `ld_sel_i` picks the target register: 0 pointer, 1 lower bound, 2 upper bound, 3 stride (low 8 bits of `ld_data_i`, two's complement), 4 FFT size N (low 4 bits, clamped to 2..10). Loading the pointer or N clears the bit-reverse index. Codes 5 to 7 change nothing. Every load takes effect on the next clock edge.
- R3: `addr_o` shows the address before the update. In mode 2'b00 (linear), a step sets the pointer to pointer + sign-extended stride, modulo 2^16.
- R4: In mode 2'b01 (circular) with lower <= upper, a step with a positive stride whose sum exceeds the upper bound reloads the pointer with the lower bound.
- R5: In circular mode with lower <= upper, a step with a negative stride whose sum falls below the lower bound reloads the pointer with the upper bound.
- R6: In circular mode with lower > upper, a step behaves exactly as in linear mode.
- R7: In mode 2'b10 (bit-reverse), `addr_o` = lower bound + (index with bits [N-1:0] reversed), modulo 2^16. A step advances the index by one, modulo 2^N, and leaves the pointer unchanged.
- R8: In mode 2'b11 (hold), a step changes neither the pointer nor the index.
- R9: A load to the pointer or to N, in the same cycle as a step, wins over the step. A load to any other register in the same cycle as a step lets the step use the old register values.
- R10: With `step_i` low and no load, the pointer and the index keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Register load strobe |
| ld_sel_i | input | 3 | Load target select |
| ld_data_i | input | 16 | Load value |
| mode_i | input | 2 | Update mode: 00 linear, 01 circular, 10 bit-reverse, 11 hold |
| step_i | input | 1 | Update strobe |
| addr_o | output | 16 | Current access address |

## Verification
A register load and a pointer step can fall in the same cycle. The stride or a bound can also be rewritten on the very edge that uses it. The bench provokes both cases directly, with a pointer load during a circular step and a stride load during a linear step. Random traffic also raises both strobes together. Each case is judged by the address seen on the following cycle. A pointer or N load must win outright. Any other load must leave that one step working from the values held before the edge.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'b00,
    MODE_CIRC = 2'b01,
    MODE_BREV = 2'b10,
    MODE_HOLD = 2'b11
  } agu_mode_e;

  typedef enum logic [2:0] {
    LD_PTR   = 3'd0,
    LD_LO    = 3'd1,
    LD_HI    = 3'd2,
    LD_STEP  = 3'd3,
    LD_FFT   = 3'd4
  } agu_ld_e;
endpackage

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int unsigned AW       = 16,
  parameter int unsigned SW       = 8,
  parameter int unsigned MIN_LOG2 = 2,
  parameter int unsigned MAX_LOG2 = 10,
  localparam int unsigned LW      = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [2:0]    ld_sel_i,
  input  logic [AW-1:0] ld_data_i,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o,
  output logic [SW-1:0] step_o,
  output logic [LW-1:0] fft_n_o
);
  import agu_pkg::*;

  logic [LW-1:0] n_raw, n_clamped;

  always_comb begin
    n_raw = ld_data_i[LW-1:0];
    if (n_raw < LW'(MIN_LOG2))      n_clamped = LW'(MIN_LOG2);
    else if (n_raw > LW'(MAX_LOG2)) n_clamped = LW'(MAX_LOG2);
    else                            n_clamped = n_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o    <= '0;
      hi_o    <= '1;
      step_o  <= SW'(1);
      fft_n_o <= LW'(MIN_LOG2);
    end else if (ld_en_i) begin
      case (ld_sel_i)
        LD_LO:   lo_o    <= ld_data_i;
        LD_HI:   hi_o    <= ld_data_i;
        LD_STEP: step_o  <= ld_data_i[SW-1:0];
        LD_FFT:  fft_n_o <= n_clamped;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int unsigned AW = 16,
  parameter int unsigned SW = 8
) (
  input  logic          circ_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [SW-1:0] step_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic [AW-1:0] ptr_nxt_o
);
  logic signed [AW+1:0] sum, lo_s, hi_s;
  logic                 bounds_ok, neg, pos;

  always_comb begin
    sum       = $signed({2'b00, ptr_i}) + $signed({{(AW+2-SW){step_i[SW-1]}}, step_i});
    lo_s      = $signed({2'b00, lo_i});
    hi_s      = $signed({2'b00, hi_i});
    bounds_ok = circ_i && (lo_i <= hi_i);
    neg       = step_i[SW-1];
    pos       = !neg && (step_i != '0);
    if (bounds_ok && pos && (sum > hi_s))      ptr_nxt_o = lo_i;
    else if (bounds_ok && neg && (sum < lo_s)) ptr_nxt_o = hi_i;
    else                                       ptr_nxt_o = sum[AW-1:0];
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int unsigned MAX_LOG2 = 10,
  localparam int unsigned LW      = $clog2(MAX_LOG2 + 1),
  localparam int unsigned IW      = $clog2(MAX_LOG2)
) (
  input  logic [MAX_LOG2-1:0] idx_i,
  input  logic [LW-1:0]       n_i,
  output logic [MAX_LOG2-1:0] rev_o,
  output logic [MAX_LOG2-1:0] mask_o
);
  logic [MAX_LOG2:0] full;

  always_comb begin
    full   = ((MAX_LOG2+1)'(1) << n_i) - (MAX_LOG2+1)'(1);
    mask_o = full[MAX_LOG2-1:0];
  end

  for (genvar g = 0; g < MAX_LOG2; g++) begin : g_rev
    int j;
    always_comb begin
      j = int'(n_i) - 1 - g;
      rev_o[g] = (j >= 0) ? idx_i[j[IW-1:0]] : 1'b0;
    end
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int unsigned AW       = 16,
  parameter int unsigned SW       = 8,
  parameter int unsigned MIN_LOG2 = 2,
  parameter int unsigned MAX_LOG2 = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_en_i,
  input  logic [2:0]    ld_sel_i,
  input  logic [15:0]   ld_data_i,
  input  logic [1:0]    mode_i,
  input  logic          step_i,
  output logic [15:0]   addr_o
);
  import agu_pkg::*;
  localparam int unsigned LW = $clog2(MAX_LOG2 + 1);

  logic [AW-1:0]       ptr_q, ptr_nxt, lo_q, hi_q;
  logic [SW-1:0]       step_q;
  logic [LW-1:0]       fft_n_q;
  logic [MAX_LOG2-1:0] idx_q, rev, mask;
  logic                ld_ptr, ld_fft, mv_ptr, mv_idx;

  agu_regs #(.AW(AW), .SW(SW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_regs (
    .clk_i, .rst_ni, .ld_en_i, .ld_sel_i, .ld_data_i,
    .lo_o(lo_q), .hi_o(hi_q), .step_o(step_q), .fft_n_o(fft_n_q)
  );

  agu_step #(.AW(AW), .SW(SW)) u_step (
    .circ_i(mode_i == MODE_CIRC), .ptr_i(ptr_q), .step_i(step_q),
    .lo_i(lo_q), .hi_i(hi_q), .ptr_nxt_o(ptr_nxt)
  );

  agu_bitrev #(.MAX_LOG2(MAX_LOG2)) u_rev (
    .idx_i(idx_q), .n_i(fft_n_q), .rev_o(rev), .mask_o(mask)
  );

  assign ld_ptr = ld_en_i && (ld_sel_i == LD_PTR);
  assign ld_fft = ld_en_i && (ld_sel_i == LD_FFT);
  assign mv_ptr = step_i && ((mode_i == MODE_LIN) || (mode_i == MODE_CIRC));
  assign mv_idx = step_i && (mode_i == MODE_BREV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ld_ptr) ptr_q <= ld_data_i;
    else if (mv_ptr) ptr_q <= ptr_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               idx_q <= '0;
    else if (ld_ptr || ld_fft) idx_q <= '0;
    else if (mv_idx)           idx_q <= (idx_q + MAX_LOG2'(1)) & mask;
  end

  assign addr_o = (mode_i == MODE_BREV) ? lo_q + {{(AW-MAX_LOG2){1'b0}}, rev} : ptr_q;
endmodule

// File: rtl/dsp_agu_chk.sv
module dsp_agu_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned SW       = 8,
  parameter int unsigned MAX_LOG2 = 10,
  localparam int unsigned LW      = $clog2(MAX_LOG2 + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ld_en_i,
  input logic [2:0]          ld_sel_i,
  input logic [AW-1:0]       ld_data_i,
  input logic [1:0]          mode_i,
  input logic                step_i,
  input logic [AW-1:0]       ptr_q,
  input logic [AW-1:0]       lo_q,
  input logic [AW-1:0]       hi_q,
  input logic [SW-1:0]       step_q,
  input logic [LW-1:0]       fft_n_q,
  input logic [MAX_LOG2-1:0] idx_q
);
  logic ldp;
  assign ldp = ld_en_i && (ld_sel_i == 3'd0);

  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldp |=> ptr_q == $past(ld_data_i));

  a_r3_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == 2'b00 && !ldp) |=>
      ptr_q == $past(ptr_q + {{(AW-SW){step_q[SW-1]}}, step_q}));

  a_r4_circ_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == 2'b01 && !ld_en_i && lo_q <= hi_q && ptr_q >= lo_q && ptr_q <= hi_q)
      |=> (ptr_q >= lo_q && ptr_q <= hi_q));

  a_r7_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, idx_q} < ((MAX_LOG2+1)'(1) << fft_n_q));

  a_r7_brev_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == 2'b10 && !ldp) |=> $stable(ptr_q));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i == 2'b11 && !ld_en_i) |=> ($stable(ptr_q) && $stable(idx_q)));

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_en_i) |=> ($stable(ptr_q) && $stable(idx_q)));
endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .SW(SW), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
  .ld_data_i(ld_data_i), .mode_i(mode_i), .step_i(step_i), .ptr_q(ptr_q),
  .lo_q(lo_q), .hi_q(hi_q), .step_q(step_q), .fft_n_q(fft_n_q), .idx_q(idx_q)
);

// File: tb/dsp_agu_tb_top.sv
module dsp_agu_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ld_en_i = 1'b0, step_i = 1'b0;
  logic [2:0]  ld_sel_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [1:0]  mode_i = '0;
  logic [15:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_ptr, m_lo, m_hi, m_step, m_n, m_idx;

  dsp_agu dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic int f_rev(int idx, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if ((idx >> (n - 1 - i)) & 1) r |= (1 << i);
    return r;
  endfunction

  function automatic int f_addr(logic [1:0] md);
    if (md == 2'b10) return (m_lo + f_rev(m_idx, m_n)) & 16'hFFFF;
    return m_ptr;
  endfunction

  function automatic int f_next_ptr(logic [1:0] md);
    int sum = m_ptr + m_step;
    if (md == 2'b01 && m_lo <= m_hi) begin
      if (m_step > 0 && sum > m_hi) return m_lo;
      if (m_step < 0 && sum < m_lo) return m_hi;
    end
    return sum & 16'hFFFF;
  endfunction

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(bit le, logic [2:0] sel, logic [15:0] d, logic [1:0] md, bit st, string req);
    int np, ni, nv;
    ld_en_i = le; ld_sel_i = sel; ld_data_i = d; mode_i = md; step_i = st;
    @(posedge clk_i);
    np = m_ptr; ni = m_idx;
    if (st && (md == 2'b00 || md == 2'b01)) np = f_next_ptr(md);
    if (st && md == 2'b10) ni = (m_idx + 1) % (1 << m_n);
    if (le) begin
      case (sel)
        3'd0: begin np = d; ni = 0; end
        3'd1: m_lo = d;
        3'd2: m_hi = d;
        3'd3: m_step = int'($signed(d[7:0]));
        3'd4: begin
          nv = d[3:0];
          m_n = (nv < 2) ? 2 : (nv > 10) ? 10 : nv;
          ni = 0;
        end
        default: ;
      endcase
    end
    m_ptr = np; m_idx = ni;
    @(negedge clk_i);
    ld_en_i = 1'b0; step_i = 1'b0;
    check(addr_o, f_addr(mode_i), req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ptr = 0; m_lo = 0; m_hi = 16'hFFFF; m_step = 1; m_n = 2; m_idx = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    check(addr_o, 0, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc(0, 0, 0, 2'b00, 1, "R1");
    check(addr_o, 1, "R1");
    cyc(0, 0, 0, 2'b10, 0, "R1");
    check(addr_o, 0, "R1");

    cyc(1, 3'd0, 16'h1234, 2'b00, 0, "R2");
    check(addr_o, 16'h1234, "R2");
    cyc(1, 3'd6, 16'hBEEF, 2'b00, 0, "R2");
    check(addr_o, 16'h1234, "R2");
    cyc(0, 0, 0, 2'b00, 0, "R10");
    check(addr_o, 16'h1234, "R10");

    cyc(1, 3'd0, 16'hFFFF, 2'b00, 0, "R3");
    cyc(0, 0, 0, 2'b00, 1, "R3");
    check(addr_o, 16'h0000, "R3");

    cyc(1, 3'd1, 16'h0100, 2'b01, 0, "R4");
    cyc(1, 3'd2, 16'h0103, 2'b01, 0, "R4");
    cyc(1, 3'd0, 16'h0102, 2'b01, 0, "R4");
    cyc(0, 0, 0, 2'b01, 1, "R4");
    check(addr_o, 16'h0103, "R4");
    cyc(0, 0, 0, 2'b01, 1, "R4");
    check(addr_o, 16'h0100, "R4");
    cyc(1, 3'd3, 16'h00FF, 2'b01, 0, "R5");
    cyc(0, 0, 0, 2'b01, 1, "R5");
    check(addr_o, 16'h0103, "R5");

    cyc(1, 3'd0, 16'h0200, 2'b01, 1, "R9");
    check(addr_o, 16'h0200, "R9");
    cyc(1, 3'd3, 16'h0005, 2'b00, 1, "R9");
    check(addr_o, 16'h01FF, "R9");

    cyc(1, 3'd1, 16'h0300, 2'b01, 0, "R6");
    cyc(1, 3'd0, 16'hFFFE, 2'b01, 0, "R6");
    cyc(0, 0, 0, 2'b01, 1, "R6");
    check(addr_o, 16'h0003, "R6");

    cyc(0, 0, 0, 2'b11, 1, "R8");
    check(addr_o, 16'h0003, "R8");

    cyc(1, 3'd1, 16'h0040, 2'b10, 0, "R7");
    cyc(1, 3'd4, 16'h0003, 2'b10, 0, "R7");
    check(addr_o, 16'h0040, "R7");
    for (int k = 1; k < 9; k++) begin
      cyc(0, 0, 0, 2'b10, 1, "R7");
      check(addr_o, 16'h0040 + f_rev(k % 8, 3), "R7");
    end
    cyc(1, 3'd4, 16'h000F, 2'b10, 0, "R7");
    cyc(0, 0, 0, 2'b10, 1, "R7");
    check(addr_o, 16'h0040 + 16'h0200, "R7");
    cyc(1, 3'd4, 16'h0001, 2'b10, 0, "R2");
    cyc(0, 0, 0, 2'b10, 1, "R2");
    check(addr_o, 16'h0042, "R2");
    cyc(0, 0, 0, 2'b00, 0, "R7");
    check(addr_o, 16'h0003, "R7");

    for (int k = 0; k < 4000; k++) begin
      bit le = ($urandom % 5) == 0;
      logic [2:0] sel = 3'($urandom % 8);
      logic [15:0] d = 16'($urandom);
      logic [1:0] md = 2'($urandom % 4);
      string tg;
      if (sel == 3'd1 || sel == 3'd2 || sel == 3'd0) d = 16'h0100 + 16'($urandom % 48);
      tg = le ? "R9" : (md == 2'b00) ? "R3" : (md == 2'b01) ? "R4" :
           (md == 2'b10) ? "R7" : "R8";
      cyc(le, sel, d, md, ($urandom % 4) != 0, tg);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule